// File: doc/BRIEF.md
# Serial Port Core with Tagged Receive Queue

This block is an asynchronous serial port. Bytes written over a small register bus go into a 16-entry transmit queue. A transmit state machine sends each one as a start bit, eight data bits least significant bit first, an optional parity bit and one stop bit. A receive state machine oversamples the line at sixteen ticks per bit and takes the middle sample of each bit. It rebuilds each character and stores it in a 16-entry receive queue. Each queue entry also keeps that character's framing, parity and break flags, so software sees every error next to the byte it belongs to.

When the receive queue is full, the incoming character is dropped and a sticky overrun flag is set. Characters already queued stay untouched. Three modem status inputs pass through a two-flop synchronizer. A change on any of them sets a sticky modem-status event. Four interrupt sources (receive level, transmit level, modem change, receive error/overrun) each have a mask bit. They come out as masked lines and as one combined line. The bit rate is set by a programmable divider, and one bit lasts 16 × divisor clocks.

Register map (2-bit address). Address 0, data: a write queues bits [7:0] for transmit. A read pops one receive entry, laid out as {brk[10], par[9], frm[8], data[7:0]}. Address 1: a write sets the configuration {odd[13], parity_en[12], divisor[11:0]}. A read gives the status {dsr[7], dcd[6], cts[5], overrun[4], tx_full[3], tx_empty[2], rx_full[1], rx_empty[0]}. Address 2: mask, read/write, bits [3:0]. Address 3: raw interrupt sources {err[3], modem[2], tx[1], rx[0]}. Writing a 1 to bit 2 or bit 3 clears that sticky source, and bit 3 also clears overrun.

Top module: `uart_tagq`

## Requirements
- R1: A received frame with a valid stop bit and no parity is queued as {0,0,0,data}, with data taken least significant bit first. A read of address 0 returns the oldest entry and removes it.
- R2: With parity enabled (config bit 12), a parity bit that does not match even parity (bit 13 = 0) or odd parity (bit 13 = 1) over the eight data bits sets entry bit 9.
- R3: A stop bit sampled low sets entry bit 8 (framing) when the frame is not a break, and it sets raw source bit 3.
- R4: A line held low through the stop bit position, with all data and parity samples low, queues exactly one entry 0x400 (bit 10 set, data 0, bits 9 and 8 clear). A new start is accepted only after the line returns high.
- R5: A character that completes while the receive queue holds 16 entries is discarded. Status bit 4 and raw bit 3 are set at once, the 16 older entries come out unchanged and in order, and writing bit 3 of address 3 clears status bit 4.
- R6: Raw source bit 0 is 1 exactly when the receive queue holds 8 or more entries. The queue never holds more than 16.
- R7: Each queued transmit byte is sent on txd as start (0), eight bits least significant bit first, the parity bit when enabled, and stop (1), each bit lasting 16 × divisor clocks. txd is high whenever nothing is being sent.
- R8: Raw source bit 1 is 1 exactly when the transmit queue holds 8 or fewer entries.
- R9: A change on cts, dcd or dsr, after two synchronizer flops, sets raw bit 2 until a 1 is written to bit 2 of address 3. Status bits 5 to 7 show the synchronized levels.
- R10: irq_vec is the raw sources ANDed with the mask, and irq_any is high when any bit of irq_vec is high.
- R11: After reset the status reads 0x005, the mask is 0, raw sources read 0x2, irq_any is low and txd is high.
- R12: A low pulse on rxd shorter than half a bit period is rejected as a false start, and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive queue at address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 14 | Write data |
| bus_rdata | output | 11 | Read data, combinational from the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts | input | 1 | Modem status input |
| dcd | input | 1 | Modem status input |
| dsr | input | 1 | Modem status input |
| irq_vec | output | 4 | Masked interrupt sources {err, modem, tx, rx} |
| irq_any | output | 1 | OR of irq_vec |

## Verification
The bound checker checks on every cycle that neither queue count goes past its depth, that a push into a full receive queue raises overrun, that overrun stays set until it is cleared, that masked sources never reach irq_vec and that txd is high whenever the transmitter is idle. The bench's scenarios are the only thing that shows the contents of the frames. Bit order, parity and error tags on each entry, break collapsing to one entry, rejection of a false start, survival of the older data after an overrun, the half-full thresholds and the waveform on txd are all checked by a scoreboard against expected items.

// File: rtl/uart_tagq_pkg.sv
package uart_tagq_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    // One receive queue entry: error tags travel with the byte.
    typedef struct packed {
        logic       brk;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } rx_entry_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;
    localparam logic [1:0] ADDR_IRQ  = 2'd3;

endpackage

// File: rtl/uart_tagq_fifo.sv
module uart_tagq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/uart_tagq_rx.sv
module uart_tagq_rx
    import uart_tagq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd_s,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      push,
    output rx_entry_t entry
);
    rx_state_e  state_q, state_d;
    logic [3:0] scnt_q;
    logic [2:0] bidx_q;
    logic [7:0] sh_q;
    logic       pbit_q;
    logic       bit_end, is_brk;

    assign bit_end = tick && (scnt_q == 4'd15);
    assign is_brk  = !rxd_s && (sh_q == 8'h00) && (!par_en || !pbit_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!rxd_s) state_d = RX_START;
            RX_START: if (tick && scnt_q == 4'd7) state_d = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && bidx_q == 3'd7) state_d = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (bit_end) state_d = RX_STOP;
            RX_STOP:  if (bit_end) state_d = rxd_s ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (rxd_s) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // Datapath: tick counter, shifter, and the tagged entry at the stop sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= '0;
            bidx_q <= '0;
            sh_q   <= '0;
            pbit_q <= 1'b0;
            push   <= 1'b0;
            entry  <= '0;
        end else begin
            push <= 1'b0;
            if (state_q != state_d) scnt_q <= '0;
            else if (tick)          scnt_q <= scnt_q + 1'b1;
            unique case (state_q)
                RX_START: bidx_q <= '0;
                RX_DATA: if (bit_end) begin
                    sh_q   <= {rxd_s, sh_q[7:1]};
                    bidx_q <= bidx_q + 1'b1;
                end
                RX_PAR: if (bit_end) pbit_q <= rxd_s;
                RX_STOP: if (bit_end) begin
                    push       <= 1'b1;
                    entry.data <= sh_q;
                    entry.brk  <= is_brk;
                    entry.frm  <= !rxd_s && !is_brk;
                    entry.par  <= !is_brk && par_en && ((^sh_q ^ pbit_q) != par_odd);
                    pbit_q     <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_tagq_tx.sv
module uart_tagq_tx
    import uart_tagq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       avail,
    input  logic [7:0] din,
    output logic       pop,
    output logic       txd,
    output logic       busy
);
    tx_state_e  state_q, state_d;
    logic [3:0] scnt_q;
    logic [2:0] bidx_q;
    logic [7:0] sh_q;
    logic       pbit_q;
    logic       bit_end;

    assign bit_end = tick && (scnt_q == 4'd15);
    assign pop     = (state_q == TX_IDLE) && avail;
    assign busy    = (state_q != TX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (avail) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && bidx_q == 3'd7) state_d = par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_PAR:   txd = pbit_q;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q <= '0;
            bidx_q <= '0;
            sh_q   <= '0;
            pbit_q <= 1'b0;
        end else begin
            if (state_q != state_d) scnt_q <= '0;
            else if (tick)          scnt_q <= scnt_q + 1'b1;
            if (pop) begin
                sh_q   <= din;
                pbit_q <= ^din ^ par_odd;
                bidx_q <= '0;
            end else if (state_q == TX_DATA && bit_end) begin
                sh_q   <= {1'b0, sh_q[7:1]};
                bidx_q <= bidx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_tagq.sv
module uart_tagq
    import uart_tagq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int DIVW    = 12,
    parameter int DEF_DIV = 27
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_addr,
    input  logic [DIVW+1:0] bus_wdata,
    output logic [10:0]     bus_rdata,
    input  logic            rxd,
    output logic            txd,
    input  logic            cts,
    input  logic            dcd,
    input  logic            dsr,
    output logic [3:0]      irq_vec,
    output logic            irq_any
);
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;
    localparam int EW   = $bits(rx_entry_t);

    logic [DIVW-1:0] div_q, bcnt_q, div_eff;
    logic            pen_q, podd_q, tick;
    logic [3:0]      mask_q, irq_raw;
    logic            rx_s1, rx_s2;
    logic [2:0]      ms_s1, ms_s2, ms_prev;
    logic            ms_q, err_q, ovr_q;

    logic            wr_acc, clr_err, clr_ms, rx_pop, tx_push, tx_pop, tx_busy;
    logic            rx_push_req, rx_full, rx_empty, tx_full, tx_empty;
    rx_entry_t       rx_entry;
    logic [EW-1:0]   rx_dout;
    logic [7:0]      tx_dout;
    logic [CW-1:0]   rx_count, tx_count;

    assign wr_acc  = bus_sel && bus_wr;
    assign tx_push = wr_acc && bus_addr == ADDR_DATA;
    assign rx_pop  = bus_sel && bus_rd && bus_addr == ADDR_DATA;
    assign clr_err = wr_acc && bus_addr == ADDR_IRQ && bus_wdata[3];
    assign clr_ms  = wr_acc && bus_addr == ADDR_IRQ && bus_wdata[2];

    // Baud tick: one pulse every div clocks (0 treated as 1).
    assign div_eff = (div_q == '0) ? DIVW'(1) : div_q;
    assign tick    = (bcnt_q >= div_eff - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= DIVW'(DEF_DIV);
            pen_q  <= 1'b0;
            podd_q <= 1'b0;
            mask_q <= '0;
            bcnt_q <= '0;
            rx_s1  <= 1'b1;
            rx_s2  <= 1'b1;
            ms_s1  <= '0;
            ms_s2  <= '0;
            ms_prev <= '0;
            ms_q   <= 1'b0;
            err_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            bcnt_q <= tick ? '0 : bcnt_q + 1'b1;
            if (wr_acc && bus_addr == ADDR_STAT) begin
                div_q  <= bus_wdata[DIVW-1:0];
                pen_q  <= bus_wdata[DIVW];
                podd_q <= bus_wdata[DIVW+1];
            end
            if (wr_acc && bus_addr == ADDR_MASK) mask_q <= bus_wdata[3:0];
            rx_s1   <= rxd;
            rx_s2   <= rx_s1;
            ms_s1   <= {dsr, dcd, cts};
            ms_s2   <= ms_s1;
            ms_prev <= ms_s2;
            if (ms_s2 != ms_prev) ms_q <= 1'b1;
            else if (clr_ms)      ms_q <= 1'b0;
            if (rx_push_req && rx_full) ovr_q <= 1'b1;
            else if (clr_err)           ovr_q <= 1'b0;
            if (rx_push_req && (rx_full || rx_entry.brk || rx_entry.par || rx_entry.frm))
                err_q <= 1'b1;
            else if (clr_err)
                err_q <= 1'b0;
        end
    end

    uart_tagq_rx rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rx_s2),
        .par_en(pen_q), .par_odd(podd_q), .push(rx_push_req), .entry(rx_entry)
    );

    uart_tagq_fifo #(.W(EW), .DEPTH(DEPTH)) rxq_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push_req), .din(rx_entry),
        .pop(rx_pop), .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    uart_tagq_fifo #(.W(8), .DEPTH(DEPTH)) txq_i (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[7:0]),
        .pop(tx_pop), .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    uart_tagq_tx tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(pen_q), .par_odd(podd_q),
        .avail(!tx_empty), .din(tx_dout), .pop(tx_pop), .txd(txd), .busy(tx_busy)
    );

    assign irq_raw = {err_q, ms_q, (tx_count <= CW'(HALF)), (rx_count >= CW'(HALF))};
    assign irq_vec = irq_raw & mask_q;
    assign irq_any = |irq_vec;

    always_comb begin
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = rx_dout;
            ADDR_STAT: bus_rdata = {3'b000, ms_s2, ovr_q, tx_full, tx_empty, rx_full, rx_empty};
            ADDR_MASK: bus_rdata = {7'b0, mask_q};
            default:   bus_rdata = {7'b0, irq_raw};
        endcase
    end
endmodule

// File: rtl/uart_tagq_chk.sv
module uart_tagq_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [$clog2(DEPTH):0] rx_count,
    input logic [$clog2(DEPTH):0] tx_count,
    input logic                   rx_push,
    input logic                   ovr,
    input logic                   ovr_clr,
    input logic                   txd,
    input logic                   tx_busy,
    input logic [3:0]             mask,
    input logic [3:0]             irq_vec
);
    assert_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_count) <= DEPTH) && (int'(tx_count) <= DEPTH));

    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_count) == DEPTH && rx_push) |=> ovr);

    assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    assert_mask_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec & ~mask) == 4'b0000);

    assert_tx_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
endmodule

bind uart_tagq uart_tagq_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .rx_push(rx_push_req), .ovr(ovr_q), .ovr_clr(clr_err), .txd(txd),
    .tx_busy(tx_busy), .mask(mask_q), .irq_vec(irq_vec)
);

// File: tb/uart_tagq_tb_top.sv
`timescale 1ns/1ps
module uart_tagq_tb_top;
    localparam int BIT = 32; // divisor 2 x 16 ticks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [13:0] bus_wdata = '0;
    logic [10:0] bus_rdata;
    logic        rxd = 1'b1, txd;
    logic        cts = 1'b0, dcd = 1'b0, dsr = 1'b0;
    logic [3:0]  irq_vec;
    logic        irq_any;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [10:0] rx_exp_q[$];
    logic [9:0]  tx_exp_q[$];

    always #10 clk = ~clk;

    uart_tagq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .cts(cts), .dcd(dcd), .dsr(dsr),
        .irq_vec(irq_vec), .irq_any(irq_any)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [13:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [10:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic set_cfg(input bit pen, input bit podd);
        bus_write(2'd1, {podd, pen, 12'd2});
    endtask

    // Driver: serialises a frame on rxd and pushes the expected tagged entry.
    task automatic send_frame(input logic [7:0] d, input bit pen, input bit podd,
                              input bit bad_par, input bit stop_v, input bit keep);
        logic p;
        p = ^d ^ podd ^ bad_par;
        @(negedge clk);
        rxd = 1'b0; repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; repeat (BIT) @(negedge clk);
        end
        if (pen) begin
            rxd = p; repeat (BIT) @(negedge clk);
        end
        rxd = stop_v; repeat (BIT) @(negedge clk);
        rxd = 1'b1; repeat (8) @(negedge clk);
        if (keep) rx_exp_q.push_back({1'b0, bad_par & pen, ~stop_v, d});
    endtask

    // Monitor for the receive side: pops the scoreboard as entries are read.
    task automatic drain_rx(input string req);
        logic [10:0] v;
        logic [10:0] e;
        while (rx_exp_q.size() > 0) begin
            bus_read(2'd0, v);
            e = rx_exp_q.pop_front();
            check_eq(req, v, e);
        end
        bus_read(2'd1, v);
        check_eq({req, " queue empty after drain"}, v[0], 1'b1);
    endtask

    task automatic send_tx(input logic [7:0] d, input bit pen, input bit podd);
        tx_exp_q.push_back({pen, podd, d});
        bus_write(2'd0, {6'b0, d});
    endtask

    // Monitor for the transmit side (R7): decodes txd and compares with the queue.
    initial begin
        logic [9:0] e;
        logic [7:0] got;
        logic       pb, sb;
        forever begin
            @(negedge clk);
            if (rst_n && !txd) begin
                repeat (BIT / 2) @(negedge clk);
                check_eq("R7 start bit low", txd, 1'b0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT) @(negedge clk);
                    got[i] = txd;
                end
                if (tx_exp_q.size() == 0) begin
                    check_eq("R7 unexpected frame", 32'd1, 32'd0);
                end else begin
                    e = tx_exp_q[0];
                    if (e[9]) begin
                        repeat (BIT) @(negedge clk);
                        pb = txd;
                        check_eq("R7 parity bit", pb, ^e[7:0] ^ e[8]);
                    end
                    repeat (BIT) @(negedge clk);
                    sb = txd;
                    check_eq("R7 data", got, e[7:0]);
                    check_eq("R7 stop bit", sb, 1'b1);
                    void'(tx_exp_q.pop_front());
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [10:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        bus_read(2'd1, v); check_eq("R11 status", v, 11'h005);
        bus_read(2'd2, v); check_eq("R11 mask", v, 11'h000);
        bus_read(2'd3, v); check_eq("R11 raw sources", v, 11'h002);
        check_eq("R11 irq_any", irq_any, 1'b0);
        check_eq("R11 txd idle", txd, 1'b1);

        // R10 masking
        bus_write(2'd2, 14'h2);
        check_eq("R10 irq_vec tx only", irq_vec, 4'h2);
        check_eq("R10 irq_any set", irq_any, 1'b1);
        bus_write(2'd2, 14'h1);
        check_eq("R10 irq_vec masked", irq_vec, 4'h0);
        check_eq("R10 irq_any clear", irq_any, 1'b0);

        // R1 plain receive
        set_cfg(1'b0, 1'b0);
        send_frame(8'hA5, 0, 0, 0, 1, 1);
        send_frame(8'h3C, 0, 0, 0, 1, 1);
        drain_rx("R1");

        // R2 parity, even then odd
        set_cfg(1'b1, 1'b0);
        send_frame(8'h5A, 1, 0, 0, 1, 1);
        send_frame(8'h5A, 1, 0, 1, 1, 1);
        set_cfg(1'b1, 1'b1);
        send_frame(8'h81, 1, 1, 0, 1, 1);
        send_frame(8'h81, 1, 1, 1, 1, 1);
        drain_rx("R2");

        // R3 framing error
        set_cfg(1'b0, 1'b0);
        bus_write(2'd3, 14'h8);
        send_frame(8'h7E, 0, 0, 0, 0, 1);
        bus_read(2'd3, v); check_eq("R3 error source", v[3], 1'b1);
        drain_rx("R3");
        bus_write(2'd3, 14'h8);

        // R4 break: line low through stop and beyond
        @(negedge clk);
        rxd = 1'b0; repeat (12 * BIT) @(negedge clk);
        rxd = 1'b1; repeat (BIT) @(negedge clk);
        rx_exp_q.push_back(11'h400);
        drain_rx("R4");
        bus_write(2'd3, 14'h8);

        // R12 false start
        rxd = 1'b0; repeat (6) @(negedge clk);
        rxd = 1'b1; repeat (3 * BIT) @(negedge clk);
        bus_read(2'd1, v); check_eq("R12 no entry", v[0], 1'b1);

        // R6 level and R5 overrun
        for (int i = 0; i < 17; i++) begin
            send_frame(8'(i + 1), 0, 0, 0, 1, i < 16);
            if (i == 6) check_eq("R6 below half", irq_vec[0], 1'b0);
            if (i == 7) check_eq("R6 at half", irq_vec[0], 1'b1);
        end
        bus_read(2'd1, v);
        check_eq("R5 overrun status", v[4], 1'b1);
        check_eq("R6 full", v[1], 1'b1);
        bus_read(2'd3, v); check_eq("R5 error source", v[3], 1'b1);
        drain_rx("R5");
        bus_write(2'd3, 14'h8);
        bus_read(2'd1, v); check_eq("R5 overrun cleared", v[4], 1'b0);

        // R9 modem status
        dcd = 1'b1; repeat (6) @(negedge clk);
        bus_read(2'd3, v); check_eq("R9 change on dcd", v[2], 1'b1);
        bus_read(2'd1, v); check_eq("R9 dcd level", v[7:5], 3'b010);
        bus_write(2'd3, 14'h4);
        bus_read(2'd3, v); check_eq("R9 cleared", v[2], 1'b0);
        cts = 1'b1; repeat (6) @(negedge clk);
        bus_read(2'd3, v); check_eq("R9 change on cts", v[2], 1'b1);

        // R7 transmit, even then odd parity
        set_cfg(1'b1, 1'b0);
        send_tx(8'hC3, 1, 0);
        send_tx(8'h01, 1, 0);
        wait (tx_exp_q.size() == 0);
        repeat (2 * BIT) @(negedge clk);
        set_cfg(1'b1, 1'b1);
        send_tx(8'h7F, 1, 1);
        wait (tx_exp_q.size() == 0);
        repeat (2 * BIT) @(negedge clk);

        // R8 transmit level
        set_cfg(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) send_tx(8'(8'h40 + i), 0, 0);
        bus_read(2'd3, v); check_eq("R8 above half", v[1], 1'b0);
        wait (tx_exp_q.size() == 0);
        repeat (2 * BIT) @(negedge clk);
        bus_read(2'd3, v); check_eq("R8 drained", v[1], 1'b1);
        check_eq("R7 idle high", txd, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule